// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block listens to an I2C bus whose clock and data lines have already been synchronised to the system clock. It finds START and repeated START conditions and shifts in the first byte after each one. It then decides whether the local slave is the target of the transfer. The seven address bits are compared with the upper seven bits of a programmed address byte. Optionally, the all-zeroes broadcast address is accepted as well. Setting the lowest bit of the programmed byte puts the block in a promiscuous mode in which every address matches.

On a match the block pulls SDA low through an open-drain output enable for the ninth clock, which is the acknowledge. It also gives a one-cycle match pulse and latches the address, the direction bit and a broadcast flag. A mode input picks when the acknowledge starts:
- **Early:** as soon as the address byte ends.
- **Late:** after SCL has been held low for a set number of system cycles.

A force-idle input parks the state machine in idle for as long as it is asserted. Transfer of data bytes after the address is not part of this block. It only waits for the next START or STOP.

Top module: `i2c_addr_matcher`

## Requirements
- R1: A START (SDA falling while SCL is high, both compared with their values in the previous cycle) begins address collection. Eight bits are sampled on SCL rising edges, MSB first. The first seven bits are the address and the eighth is the direction (1 = read).
- R2: A match is declared when the received address equals `own_addr_i[7:1]`, for either direction. `match_o` is high for exactly one cycle, the cycle after the SCL falling edge that ends the eighth bit. `match_addr_o` and `match_rd_o` take the received values in that same cycle.
- R3: When `own_addr_i[0]` is 1, every 7-bit address matches.
- R4: With `bcast_en_i` = 1, address 0 matches and `match_bcast_o` is 1. With `bcast_en_i` = 0, address 0 does not match unless the programmed address or R3 allows it.
- R5: On no match there is no `match_o` pulse. `sda_oe_o` stays 0 until the next START or STOP, and the latched outputs keep their earlier values.
- R6: With `ack_late_i` = 0, `sda_oe_o` is 1 in the same cycle as the `match_o` pulse. It stays 1 through the ninth SCL high phase and drops in the cycle after the ninth SCL falling edge.
- R7: With `ack_late_i` = 1, `sda_oe_o` stays 0 in the `match_o` cycle. It rises HOLD_CYCLES cycles later while SCL stays low, and is then released as in R6.
- R8: A repeated START during address collection discards the bits gathered so far and restarts collection.
- R9: A STOP (SDA rising while SCL is high) returns the block to idle. SCL clocks that follow without a new START produce no match and no acknowledge.
- R10: While `force_idle_i` is 1 the block stays idle, with no match and `sda_oe_o` = 0. After it is released, the next START is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL |
| sda_i | input | 1 | Synchronised SDA (bus level) |
| own_addr_i | input | 8 | Programmed address in [7:1]; bit 0 selects match-all |
| bcast_en_i | input | 1 | Accept the all-zeroes address as well |
| force_idle_i | input | 1 | Hold the state machine in idle |
| ack_late_i | input | 1 | 0: acknowledge at byte end; 1: after the SCL low hold |
| sda_oe_o | output | 1 | Open-drain enable: pull SDA low |
| match_o | output | 1 | One-cycle match pulse |
| match_addr_o | output | 7 | Address of the last match |
| match_rd_o | output | 1 | Direction of the last match (1 = read) |
| match_bcast_o | output | 1 | Last match was on the broadcast address |

## Verification
The hardest states to reach from the ports involve a bus condition arriving while the byte is only partly collected.

**Repeated START:** the bench drives a repeated START after four address bits and then a complete matching byte. It checks that exactly one match is reported, with the address of the second byte.

**STOP:** the bench drives a STOP after three bits and then keeps clocking a matching pattern with no new START. It checks that neither the match pulse nor the output enable appears.

**Acknowledge timing:** the bench models the bus as a wired AND of the master's drive and the block's pull-down. It samples the acknowledge at fixed distances from the eighth SCL falling edge, which separates the early and late modes.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_HOLD,
    ST_ACK,
    ST_SKIP
  } am_state_e;
endpackage

// File: rtl/i2c_am_cond.sv
// Bus condition detector: compares synchronised SCL/SDA with the previous sample.
module i2c_am_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    start_o = scl_q & scl_i & sda_q & ~sda_i;
    stop_o  = scl_q & scl_i & ~sda_q & sda_i;
    rise_o  = ~scl_q & scl_i;
    fall_o  = scl_q & ~scl_i;
  end
endmodule

// File: rtl/i2c_am_shift.sv
// MSB-first shifter with a saturating bit counter.
module i2c_am_shift #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          rise_i,
  input  logic          sda_i,
  output logic [BW-1:0] byte_o,
  output logic          full_o
);
  localparam int CW = $clog2(BW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(BW);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      byte_o <= '0;
    end else if (clear_i) begin
      cnt_q  <= '0;
    end else if (rise_i && (cnt_q != CNT_FULL)) begin
      byte_o <= {byte_o[BW-2:0], sda_i};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign full_o = (cnt_q == CNT_FULL);

  // R1: bit counter never passes the byte length
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_FULL);
endmodule

// File: rtl/i2c_am_cmp.sv
// Address compare: programmed, broadcast and match-all.
module i2c_am_cmp #(
  parameter int AW = 7
) (
  input  logic [AW:0] rx_byte_i,
  input  logic [AW:0] own_byte_i,
  input  logic        bcast_en_i,
  output logic        hit_o,
  output logic        bcast_hit_o
);
  logic [AW-1:0] rx_addr;
  logic          own_hit, any_hit;

  always_comb begin
    rx_addr     = rx_byte_i[AW:1];
    own_hit     = (rx_addr == own_byte_i[AW:1]);
    any_hit     = own_byte_i[0];
    bcast_hit_o = bcast_en_i && (rx_addr == '0);
    hit_o       = own_hit || any_hit || bcast_hit_o;
  end
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import i2c_am_pkg::*;
#(
  parameter int AW          = 7,
  parameter int HOLD_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [AW:0]   own_addr_i,
  input  logic          bcast_en_i,
  input  logic          force_idle_i,
  input  logic          ack_late_i,
  output logic          sda_oe_o,
  output logic          match_o,
  output logic [AW-1:0] match_addr_o,
  output logic          match_rd_o,
  output logic          match_bcast_o
);
  localparam int BW = AW + 1;
  localparam int HW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

  am_state_e     state_q;
  logic          start_w, stop_w, rise_w, fall_w;
  logic          sh_clear, sh_full;
  logic [BW-1:0] sh_byte;
  logic          hit_w, bc_hit_w;
  logic [HW-1:0] hold_q;
  logic          ninth_q;

  i2c_am_cond u_cond (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .start_o (start_w),
    .stop_o  (stop_w),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );

  assign sh_clear = start_w || force_idle_i || (state_q != ST_ADDR);

  i2c_am_shift #(.BW(BW)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .clear_i (sh_clear),
    .rise_i  (rise_w),
    .sda_i   (sda_i),
    .byte_o  (sh_byte),
    .full_o  (sh_full)
  );

  i2c_am_cmp #(.AW(AW)) u_cmp (
    .rx_byte_i   (sh_byte),
    .own_byte_i  (own_addr_i),
    .bcast_en_i  (bcast_en_i),
    .hit_o       (hit_w),
    .bcast_hit_o (bc_hit_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      sda_oe_o      <= 1'b0;
      match_o       <= 1'b0;
      match_addr_o  <= '0;
      match_rd_o    <= 1'b0;
      match_bcast_o <= 1'b0;
      hold_q        <= '0;
      ninth_q       <= 1'b0;
    end else begin
      match_o <= 1'b0;
      if (force_idle_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_w) begin
        state_q  <= ST_ADDR;
        sda_oe_o <= 1'b0;
      end else if (stop_w) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR: begin
            if (sh_full && fall_w) begin
              if (hit_w) begin
                match_o       <= 1'b1;
                match_addr_o  <= sh_byte[BW-1:1];
                match_rd_o    <= sh_byte[0];
                match_bcast_o <= bc_hit_w;
                ninth_q       <= 1'b0;
                hold_q        <= '0;
                if (ack_late_i) begin
                  state_q <= ST_HOLD;
                end else begin
                  state_q  <= ST_ACK;
                  sda_oe_o <= 1'b1;
                end
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          ST_HOLD: begin
            if (rise_w) begin
              state_q  <= ST_ACK;
              sda_oe_o <= 1'b1;
              ninth_q  <= 1'b1;
            end else if (!scl_i) begin
              if (hold_q == HOLD_LAST) begin
                state_q  <= ST_ACK;
                sda_oe_o <= 1'b1;
              end else begin
                hold_q <= hold_q + 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (rise_w) ninth_q <= 1'b1;
            if (fall_w && ninth_q) begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: match indication is a single-cycle pulse
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
    match_o |=> !match_o);

  // R6: early mode drives the acknowledge together with the pulse
  p_early_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (match_o && !$past(ack_late_i)) |-> sda_oe_o);

  // R7: late mode keeps SDA released in the pulse cycle
  p_late_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (match_o && $past(ack_late_i)) |-> !sda_oe_o);

  // R8: a START always restarts address collection
  p_start_addr_r8: assert property (@(posedge clk) disable iff (rst)
    (start_w && !force_idle_i) |=> (state_q == ST_ADDR && !sda_oe_o));

  // R9: a STOP returns to idle
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (stop_w && !force_idle_i) |=> (state_q == ST_IDLE));

  // R10: force-idle releases the bus and suppresses matches
  p_force_idle_r10: assert property (@(posedge clk) disable iff (rst)
    force_idle_i |=> (!sda_oe_o && !match_o && state_q == ST_IDLE));
endmodule

// File: tb/test_i2c_addr_matcher.sv
module test_i2c_addr_matcher;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [7:0] own_addr = 8'h74;
  logic       bcast_en = 1'b0, force_idle = 1'b0, ack_late = 1'b0;
  logic       sda_oe, match_p, match_rd, match_bc;
  logic [6:0] match_addr;
  logic       sda_bus;
  int checks = 0, errors = 0;
  int pulse_cnt = 0, oe_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_addr_matcher #(.AW(7), .HOLD_CYCLES(4)) i_i2c_addr_matcher (
    .clk           (clk),
    .rst           (rst),
    .scl_i         (scl_m),
    .sda_i         (sda_bus),
    .own_addr_i    (own_addr),
    .bcast_en_i    (bcast_en),
    .force_idle_i  (force_idle),
    .ack_late_i    (ack_late),
    .sda_oe_o      (sda_oe),
    .match_o       (match_p),
    .match_addr_o  (match_addr),
    .match_rd_o    (match_rd),
    .match_bcast_o (match_bc)
  );

  always @(negedge clk) begin
    if (!rst && match_p) pulse_cnt++;
    if (!rst && sda_oe) oe_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wait_n(H);
    sda_m = 1'b0; wait_n(H);
    scl_m = 1'b0; wait_n(2);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wait_n(H);
    scl_m = 1'b1; wait_n(H);
    sda_m = 1'b0; wait_n(H);
    scl_m = 1'b0; wait_n(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_n(H);
    scl_m = 1'b1; wait_n(H);
    sda_m = 1'b1; wait_n(H);
  endtask

  task automatic bus_bit(input logic b);
    sda_m = b; wait_n(H);
    scl_m = 1'b1; wait_n(H);
    scl_m = 1'b0;
  endtask

  // Full address phase plus ninth clock; checks pulse, latches and ACK timing.
  task automatic addr_phase(input string req, input logic [6:0] a, input logic rw,
                            input bit exp_match, input bit exp_bc, input bit rstart);
    int p0, o0;
    logic [6:0] la;
    logic lr, lb;
    p0 = pulse_cnt; o0 = oe_cnt;
    la = match_addr; lr = match_rd; lb = match_bc;
    if (rstart) bus_rstart(); else bus_start();
    for (int i = 6; i >= 0; i--) bus_bit(a[i]);
    bus_bit(rw);
    wait_n(1);
    chk({req, " pulse after 8th fall"}, int'(match_p), int'(exp_match));
    chk({req, " oe in pulse cycle"}, int'(sda_oe), int'(exp_match && !ack_late));
    wait_n(2);
    chk({req, " oe 3 cycles after fall"}, int'(sda_oe), int'(exp_match && !ack_late));
    wait_n(H - 4);
    chk({req, " oe before 9th rise"}, int'(sda_oe), int'(exp_match));
    sda_m = 1'b1; wait_n(1);
    scl_m = 1'b1; wait_n(H / 2);
    chk({req, " SDA level in 9th high"}, int'(sda_bus), int'(!exp_match));
    wait_n(H / 2);
    scl_m = 1'b0; wait_n(2);
    chk({req, " oe released after 9th fall"}, int'(sda_oe), 0);
    chk({req, " pulse count"}, pulse_cnt - p0, int'(exp_match));
    if (exp_match) begin
      chk({req, " latched address"}, int'(match_addr), int'(a));
      chk({req, " latched direction"}, int'(match_rd), int'(rw));
      chk({req, " broadcast flag"}, int'(match_bc), int'(exp_bc));
    end else begin
      chk({req, " no acknowledge cycles"}, oe_cnt - o0, 0);
      chk({req, " latches kept"}, int'({la, lr, lb}), int'({match_addr, match_rd, match_bc}));
    end
    wait_n(H);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R2 reset match_o", int'(match_p), 0);
    chk("R6 reset sda_oe_o", int'(sda_oe), 0);
    chk("R2 reset latches", int'({match_addr, match_rd, match_bc}), 0);
  endtask

  task automatic t_write_read();
    own_addr = 8'h74; bcast_en = 1'b0; ack_late = 1'b0;
    addr_phase("R1 R2 R6 write", 7'h3A, 1'b0, 1, 0, 0);
    addr_phase("R1 R2 read", 7'h3A, 1'b1, 1, 0, 0);
  endtask

  task automatic t_mismatch();
    addr_phase("R5 mismatch", 7'h3B, 1'b0, 0, 0, 0);
    addr_phase("R5 mismatch msb", 7'h7A, 1'b1, 0, 0, 0);
  endtask

  task automatic t_bcast();
    bcast_en = 1'b1;
    addr_phase("R4 bcast on", 7'h00, 1'b0, 1, 1, 0);
    addr_phase("R4 own with bcast on", 7'h3A, 1'b0, 1, 0, 0);
    bcast_en = 1'b0;
    addr_phase("R4 bcast off", 7'h00, 1'b0, 0, 0, 0);
  endtask

  task automatic t_any();
    own_addr = 8'h75;
    addr_phase("R3 match-all", 7'h55, 1'b1, 1, 0, 0);
    addr_phase("R3 match-all zero", 7'h00, 1'b0, 1, 0, 0);
    own_addr = 8'h74;
  endtask

  task automatic t_late();
    ack_late = 1'b1;
    addr_phase("R7 late ack", 7'h3A, 1'b1, 1, 0, 0);
    ack_late = 1'b0;
  endtask

  task automatic t_rstart();
    int p0;
    p0 = pulse_cnt;
    bus_start();
    bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1); bus_bit(1'b0);
    addr_phase("R8 repeated start", 7'h3A, 1'b1, 1, 0, 1);
    chk("R8 one pulse total", pulse_cnt - p0, 1);
  endtask

  task automatic t_stop_mid();
    int p0, o0;
    logic [7:0] pat;
    p0 = pulse_cnt; o0 = oe_cnt;
    pat = 8'h74;
    bus_start();
    bus_bit(1'b0); bus_bit(1'b1); bus_bit(1'b1);
    bus_stop();
    scl_m = 1'b0; wait_n(H);
    for (int i = 7; i >= 0; i--) bus_bit(pat[i]);
    wait_n(H);
    sda_m = 1'b1; scl_m = 1'b1; wait_n(H);
    scl_m = 1'b0; wait_n(H);
    chk("R9 no match after STOP", pulse_cnt - p0, 0);
    chk("R9 no ack after STOP", oe_cnt - o0, 0);
    bus_stop();
  endtask

  task automatic t_force();
    force_idle = 1'b1;
    addr_phase("R10 forced idle", 7'h3A, 1'b0, 0, 0, 0);
    force_idle = 1'b0;
    addr_phase("R10 after release", 7'h3A, 1'b0, 1, 0, 0);
  endtask

  initial begin
    wait_n(4);
    rst = 1'b0;
    wait_n(4);
    t_reset();
    t_write_read();
    t_mismatch();
    t_bcast();
    t_any();
    t_late();
    t_rstart();
    t_stop_mid();
    t_force();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule